// File: doc/BRIEF.md
# Egress Ones-Complement Checksum Inserter

This block sits in an egress path and handles one packet segment at a time. A segment arrives as a byte stream on a valid/ready input. The controls for the segment are sampled with its first byte: an enable, an 8-bit offset where summing begins, an 8-bit offset where the result is patched, and a 16-bit seed. The whole segment, up to `MAX_LEN` bytes, is stored in an internal byte array.

While the bytes are stored, a running 16-bit ones-complement sum is kept. It covers every byte from the start offset to the end of the segment and begins from the seed. Offsets always count from byte 0 of the current segment, whether or not the segment is the first one of a packet.

Once the last byte is in, the segment is replayed on a valid/ready output. The inverted sum replaces the two bytes at the patch offset. If the controls are illegal, an error flag is raised and the segment is replayed unmodified. No new segment is accepted until the previous one has been replayed in full.

Top module: `egr_csum_insert`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: When `in_csum_en` is 0 and start, destination and seed are all zero, the segment is replayed byte for byte, with the same length and `out_err` = 0.
- R3: Only bytes at segment offsets greater than or equal to `in_start` enter the sum. Bytes before the start offset have no effect on the written value.
- R4: The byte at offset start+2k is added to sum bits [7:0], and the byte at start+2k+1 is added to bits [15:8]. The seed is added as a whole 16-bit word, so seed[7:0] pairs with the byte at the start offset.
- R5: Every addition is a 16-bit ones-complement add: a carry out of bit 15 is added back into bit 0.
- R6: When an odd number of bytes is summed, the last byte sits alone in its lane and its missing partner counts as zero.
- R7: With checksumming enabled and legal controls, output byte `dest` carries the inverted sum bits [7:0] and byte `dest+1` carries bits [15:8]. Every other byte is unchanged.
- R8: With checksumming enabled, controls are legal only when dest+2 <= segment length. Otherwise `out_err` is 1 for the whole replay and the data is unchanged.
- R9: With checksumming disabled, a nonzero start, destination or seed sets `out_err` to 1 for the whole replay, and the data is unchanged.
- R10: The cycle after the last input byte is accepted, `out_valid` is 1 and `in_ready` is 0. The cycle after the last output byte is taken, `in_ready` is 1 and `out_valid` is 0. `out_last` marks the final byte.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and `out_err` hold their values.
- R12: Segments of any length from 1 to `MAX_LEN` bytes are handled, including a full-length segment with start and destination near its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts input bytes |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the segment |
| in_csum_en | input | 1 | Checksum enable, sampled with the first byte |
| in_start | input | 8 | Sum start offset, sampled with the first byte |
| in_dest | input | 8 | Patch offset, sampled with the first byte |
| in_seed | input | 16 | Sum seed, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the replayed segment |
| out_err | output | 1 | Illegal controls for this segment, valid with `out_valid` |

## Verification
The assertions assume that a segment never exceeds `MAX_LEN` bytes; a byte counter in the checker flags a violation. They also assume the consumer's `out_ready` may stall freely but the producer only presents bytes while filling. The directed stimulus keeps every segment within the limit and holds the controls steady across each segment. It drives the output side with both steady and gapped ready patterns, so that the hold and hand-over properties are exercised in both settings.

// File: rtl/egr_csum_pkg.sv
package egr_csum_pkg;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_PLAY = 1'b1
    } phase_e;

    typedef struct packed {
        logic        en;
        logic [7:0]  start;
        logic [7:0]  dest;
        logic [15:0] seed;
    } seg_ctl_t;

    // 16-bit ones-complement add with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    // place a byte in the low or high lane of a 16-bit word
    function automatic logic [15:0] lane_word(input logic [7:0] d, input logic hi);
        return hi ? {d, 8'h00} : {8'h00, d};
    endfunction

endpackage

// File: rtl/egr_csum_ram.sv
module egr_csum_ram #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/egr_csum_accum.sv
module egr_csum_accum
    import egr_csum_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat,
    input  logic          first,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    data,
    input  logic          en,
    input  logic [7:0]    start,
    input  logic [15:0]   seed,
    output logic [15:0]   sum
);
    logic [15:0] base;
    logic [15:0] nxt;
    logic        hit;
    logic        hi;

    always_comb begin
        base = first ? (en ? seed : 16'h0000) : sum;
        hit  = en && (32'(idx) >= 32'(start));
        hi   = idx[0] ^ start[0];
        nxt  = hit ? oc_add(base, lane_word(data, hi)) : base;
    end

    always_ff @(posedge clk) begin
        if (rst)       sum <= 16'h0000;
        else if (beat) sum <= nxt;
    end
endmodule

// File: rtl/egr_csum_check.sv
module egr_csum_check
    import egr_csum_pkg::*;
#(
    parameter int LW = 9
) (
    input  seg_ctl_t      ctl,
    input  logic [LW-1:0] len,
    output logic          err,
    output logic          patch
);
    logic bad_off;
    logic bad_idle;

    always_comb begin
        bad_off  = ctl.en && ((32'(ctl.dest) + 32'd2) > 32'(len));
        bad_idle = !ctl.en && ((ctl.start != 8'd0) || (ctl.dest != 8'd0) || (ctl.seed != 16'd0));
        err      = bad_off || bad_idle;
        patch    = ctl.en && !err;
    end
endmodule

// File: rtl/egr_csum_seq.sv
module egr_csum_seq
    import egr_csum_pkg::*;
#(
    parameter int MAX_LEN = 256,
    parameter int AW      = 8,
    parameter int LW      = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_last,
    output logic          beat,
    output logic          first,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [LW-1:0] len
);
    phase_e ph;

    assign in_ready  = (ph == PH_FILL);
    assign out_valid = (ph == PH_PLAY);
    assign beat      = in_valid && in_ready;
    assign first     = (wr_ptr == '0);
    assign out_last  = out_valid && ((32'(rd_ptr) + 32'd1) == 32'(len));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_FILL;
            wr_ptr <= '0;
            rd_ptr <= '0;
            len    <= '0;
        end else begin
            case (ph)
                PH_FILL: begin
                    if (beat) begin
                        if (in_last) begin
                            len    <= LW'(32'(wr_ptr) + 32'd1);
                            wr_ptr <= '0;
                            ph     <= PH_PLAY;
                        end else begin
                            wr_ptr <= wr_ptr + 1'b1;
                        end
                    end
                end
                PH_PLAY: begin
                    if (out_ready) begin
                        if (out_last) begin
                            rd_ptr <= '0;
                            ph     <= PH_FILL;
                        end else begin
                            rd_ptr <= rd_ptr + 1'b1;
                        end
                    end
                end
                default: ph <= PH_FILL;
            endcase
        end
    end
endmodule

// File: rtl/egr_csum_insert.sv
module egr_csum_insert
    import egr_csum_pkg::*;
#(
    parameter int MAX_LEN = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_csum_en,
    input  logic [7:0]  in_start,
    input  logic [7:0]  in_dest,
    input  logic [15:0] in_seed,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        out_err
);
    localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int LW = $clog2(MAX_LEN + 1);

    logic          beat;
    logic          first;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] len;
    logic [7:0]    rd_data;
    logic [15:0]   sum;
    logic [15:0]   fill;
    logic          err;
    logic          patch;
    seg_ctl_t      ctl_q;
    logic          en_eff;
    logic [7:0]    start_eff;
    logic [15:0]   seed_eff;

    egr_csum_seq #(.MAX_LEN(MAX_LEN), .AW(AW), .LW(LW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_last (out_last),
        .beat     (beat),
        .first    (first),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .len      (len)
    );

    egr_csum_ram #(.DEPTH(MAX_LEN), .AW(AW)) u_ram (
        .clk  (clk),
        .we   (beat),
        .waddr(wr_ptr),
        .wdata(in_data),
        .raddr(rd_ptr),
        .rdata(rd_data)
    );

    // controls are taken from the ports on the first byte, from the register after
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (beat && first) begin
            ctl_q.en    <= in_csum_en;
            ctl_q.start <= in_start;
            ctl_q.dest  <= in_dest;
            ctl_q.seed  <= in_seed;
        end
    end

    assign en_eff    = first ? in_csum_en : ctl_q.en;
    assign start_eff = first ? in_start   : ctl_q.start;
    assign seed_eff  = first ? in_seed    : ctl_q.seed;

    egr_csum_accum #(.AW(AW)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .beat (beat),
        .first(first),
        .idx  (wr_ptr),
        .data (in_data),
        .en   (en_eff),
        .start(start_eff),
        .seed (seed_eff),
        .sum  (sum)
    );

    egr_csum_check #(.LW(LW)) u_chk (
        .ctl  (ctl_q),
        .len  (len),
        .err  (err),
        .patch(patch)
    );

    assign fill = ~sum;

    always_comb begin
        out_data = rd_data;
        if (patch && (32'(rd_ptr) == 32'(ctl_q.dest)))
            out_data = fill[7:0];
        else if (patch && (32'(rd_ptr) == (32'(ctl_q.dest) + 32'd1)))
            out_data = fill[15:8];
    end

    assign out_err = err && out_valid;
endmodule

// File: rtl/egr_csum_sva.sv
module egr_csum_sva #(
    parameter int MAX_LEN = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_last,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       out_err
);
    int unsigned seen;

    always_ff @(posedge clk) begin
        if (rst)                                   seen <= 0;
        else if (in_valid && in_ready && in_last)  seen <= 0;
        else if (in_valid && in_ready)             seen <= seen + 1;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    a_r10_enter_replay: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> (out_valid && !in_ready));

    a_r10_leave_replay: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    a_r11_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_err)));

    a_r12_fits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_last) |-> (seen + 1 < MAX_LEN));
endmodule

bind egr_csum_insert egr_csum_sva #(.MAX_LEN(MAX_LEN)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .out_err  (out_err)
);

// File: tb/egr_csum_insert_test.sv
`timescale 1ns/1ps
module egr_csum_insert_test;
    localparam int MAXL = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_csum_en = 1'b0;
    logic [7:0]  in_start = 8'h00;
    logic [7:0]  in_dest = 8'h00;
    logic [15:0] in_seed = 16'h0000;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_err;

    logic [7:0] tx [MAXL];
    logic [7:0] ex [MAXL];
    logic [7:0] rx [MAXL];
    int rx_n;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    egr_csum_insert #(.MAX_LEN(MAXL)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_csum_en(in_csum_en), .in_start(in_start), .in_dest(in_dest), .in_seed(in_seed),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_err(out_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected output from the requirements
    task automatic model(input int len, input bit en, input int st, input int ds,
                         input int sd, output bit e);
        logic [31:0] acc;
        for (int i = 0; i < len; i++) ex[i] = tx[i];
        e = (en && (ds + 2 > len)) || (!en && (st != 0 || ds != 0 || sd != 0));
        if (en && !e) begin
            acc = 32'(sd);
            for (int i = st; i < len; i++)
                acc = acc + (((i - st) % 2 == 0) ? 32'(tx[i]) : (32'(tx[i]) << 8));
            while ((acc >> 16) != 0) acc = (acc & 32'hFFFF) + (acc >> 16);
            ex[ds]     = ~acc[7:0];
            ex[ds + 1] = ~acc[15:8];
        end
    endtask

    task automatic send_seg(input int len, input bit en, input int st, input int ds, input int sd);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_data    = tx[i];
            in_last    = (i == len - 1);
            in_csum_en = en;
            in_start   = 8'(st);
            in_dest    = 8'(ds);
            in_seed    = 16'(sd);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk("R10", "out_valid after last input", int'(out_valid), 1);
        chk("R10", "in_ready after last input", int'(in_ready), 0);
    endtask

    task automatic recv_seg(input int len, input bit bp, output int last_at, output bit got_err);
        int   guard = 0;
        bit   have_hold = 0;
        bit   hold_bad = 0;
        logic [7:0] hold_d = 8'h00;
        rx_n = 0;
        last_at = -1;
        got_err = 1'b0;
        while (rx_n < len && guard < 10 * len + 20) begin
            @(negedge clk);
            out_ready = bp ? ((guard % 3) != 0) : 1'b1;
            guard++;
            if (have_hold && (out_data !== hold_d || !out_valid)) hold_bad = 1;
            if (out_valid && out_ready) begin
                rx[rx_n] = out_data;
                if (rx_n == 0) got_err = out_err;
                if (out_last) last_at = rx_n;
                rx_n++;
            end
            have_hold = out_valid && !out_ready;
            hold_d    = out_data;
        end
        if (bp) chk("R11", "data held under stall", int'(hold_bad), 0);
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10", "in_ready after replay", int'(in_ready), 1);
        chk("R10", "out_valid after replay", int'(out_valid), 0);
    endtask

    task automatic run_seg(input string req, input int len, input bit en, input int st,
                           input int ds, input int sd, input bit bp);
        bit e;
        bit got_err;
        int last_at;
        int bad_at = -1;
        model(len, en, st, ds, sd, e);
        send_seg(len, en, st, ds, sd);
        recv_seg(len, bp, last_at, got_err);
        chk(req, "byte count", rx_n, len);
        for (int i = 0; i < len && i < rx_n; i++)
            if (bad_at < 0 && rx[i] !== ex[i]) bad_at = i;
        if (bad_at < 0) chk(req, "segment data", 0, 0);
        else chk(req, $sformatf("byte %0d", bad_at), int'(rx[bad_at]), int'(ex[bad_at]));
        chk(req, "last marker position", last_at, len - 1);
        chk(req, "error flag", int'(got_err), int'(e));
    endtask

    task automatic t_reset;
        chk("R1", "in_ready out of reset", int'(in_ready), 1);
        chk("R1", "out_valid out of reset", int'(out_valid), 0);
    endtask

    task automatic t_pass;
        for (int i = 0; i < 10; i++) tx[i] = 8'(i * 17 + 3);
        run_seg("R2", 10, 0, 0, 0, 0, 0);
        tx[0] = 8'hC3;
        run_seg("R2", 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_range;
        logic [7:0] c0, c1;
        for (int i = 0; i < 12; i++) tx[i] = 8'(i * 29 + 7);
        tx[1] = 8'h00; tx[2] = 8'h00;
        run_seg("R3", 12, 1, 5, 1, 16'h0102, 0);
        c0 = rx[1]; c1 = rx[2];
        tx[0] = 8'h5A; tx[3] = 8'hF0; tx[4] = 8'h11;
        run_seg("R3", 12, 1, 5, 1, 16'h0102, 0);
        chk("R3", "low byte independent of prefix", int'(rx[1]), int'(c0));
        chk("R3", "high byte independent of prefix", int'(rx[2]), int'(c1));
    endtask

    task automatic t_lane;
        for (int i = 0; i < 6; i++) tx[i] = 8'h00;
        tx[3] = 8'h01;
        run_seg("R4", 6, 1, 2, 0, 16'h1234, 0);
        chk("R4", "low lane byte", int'(rx[0]), 8'hCB);
        chk("R4", "high lane byte", int'(rx[1]), 8'hEC);
    endtask

    task automatic t_carry;
        for (int i = 0; i < 4; i++) tx[i] = 8'hFF;
        run_seg("R5", 4, 1, 0, 0, 16'hFFFF, 0);
        chk("R5", "folded low byte", int'(rx[0]), 8'h00);
        chk("R5", "folded high byte", int'(rx[1]), 8'h00);
    endtask

    task automatic t_odd;
        for (int i = 0; i < 5; i++) tx[i] = 8'h00;
        tx[4] = 8'h80;
        run_seg("R6", 5, 1, 0, 0, 0, 0);
        chk("R6", "odd byte in low lane", int'(rx[0]), 8'h7F);
        chk("R6", "zero pad in high lane", int'(rx[1]), 8'hFF);
    endtask

    task automatic t_dest_edge;
        for (int i = 0; i < 8; i++) tx[i] = 8'(i * 37 + 1);
        run_seg("R7", 8, 1, 0, 6, 16'hA55A, 0);
        for (int i = 0; i < 16; i++) tx[i] = 8'(i * 13 + 90);
        run_seg("R7", 16, 1, 3, 9, 16'h00FE, 0);
    endtask

    task automatic t_err_dest;
        for (int i = 0; i < 8; i++) tx[i] = 8'(i + 40);
        run_seg("R8", 8, 1, 0, 7, 16'h1111, 0);
        run_seg("R8", 8, 1, 2, 200, 0, 0);
    endtask

    task automatic t_err_idle;
        for (int i = 0; i < 7; i++) tx[i] = 8'(i * 3 + 200);
        run_seg("R9", 7, 0, 0, 0, 16'h0001, 0);
        run_seg("R9", 7, 0, 3, 0, 0, 0);
    endtask

    task automatic t_stall;
        for (int i = 0; i < 20; i++) tx[i] = 8'(i * 11 + 5);
        run_seg("R11", 20, 1, 3, 10, 16'h7E81, 1);
    endtask

    task automatic t_full;
        for (int i = 0; i < MAXL; i++) tx[i] = 8'(i) ^ 8'h5A;
        run_seg("R12", MAXL, 1, 200, 254, 16'h0F0F, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pass();
        t_range();
        t_lane();
        t_carry();
        t_odd();
        t_dest_edge();
        t_err_dest();
        t_err_idle();
        t_stall();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule